// File: doc/BRIEF.md
# Serial Receive Buffer with Character Timeout

This block holds received characters for a serial port until software reads them. Its input is a stream of byte strobes and break strobes from a deserializer. In buffered mode the bytes go into a 16-entry queue. A programmable threshold tells the interrupt logic when enough bytes are waiting. A timer flags bytes that have sat in the queue for four character times with no activity. In unbuffered mode a single holding register stands in for the queue.

The block also keeps the receive-side status flags: data ready, break seen, overrun and timeout pending. A configuration write selects the mode and the threshold, and can flush the queue. A status-read strobe clears the sticky error flags. The character time comes in as a clock-cycle count on `char_cycles`, so the block does not need to know the baud rate or the frame format. The transmit queue is not part of this block. The block only produces the one-cycle flush request for it.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the block is in unbuffered mode with the threshold code 00. `level`, `data_ready`, `break_flag`, `overrun`, `timeout_pend`, `trig_reached` and `tx_flush` are all 0, and `rd_data` is 0x00.
- R2: In buffered mode up to 16 bytes are stored. `rd_data` shows the oldest byte, and each `rd_strobe` removes it. `level` gives the number of stored bytes one cycle after each push or pop.
- R3: In buffered mode `trig_reached` is 1 when `level` is at least 1, 4, 8 or 14, for `cfg_trig` codes 00, 01, 10 and 11. In unbuffered mode it follows `data_ready`.
- R4: In buffered mode, a byte or break that arrives while `level` is 16 is dropped, even if a read happens in the same cycle. The stored bytes are kept and `overrun` is set.
- R5: In buffered mode, a read of an empty queue returns 0x00 and changes nothing. `data_ready` is 1 exactly when `level` is nonzero. `break_flag` clears when `level` reaches 0.
- R6: A `rx_break` strobe stores the byte 0x00 and sets `break_flag` and `data_ready`. A `rx_valid` in the same cycle is ignored.
- R7: In buffered mode, a received byte or break restarts the timeout, and so does a read that leaves bytes behind. The timeout lasts 4*`char_cycles` clock edges. `timeout_pend` rises on that edge if the queue is not empty. Any `rd_strobe` clears it.
- R8: A configuration write with `cfg_rx_clr` set, or one that changes the mode bit, empties the queue. It clears `data_ready`, `break_flag`, `timeout_pend` and the holding register, and stops the timer. `overrun` is left as it was.
- R9: `tx_flush` is a one-cycle pulse on the cycle after a configuration write that has `cfg_tx_clr` set or changes the mode bit.
- R10: In unbuffered mode, an arriving byte replaces the holding register and sets `data_ready`. If `data_ready` was already set, `overrun` is also set. A read returns the holding register and clears `data_ready` and `break_flag`.
- R11: `stat_rd` clears `overrun` and `break_flag`. A new overrun or break in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break condition strobe |
| rd_strobe | input | 1 | Read of the receive data register |
| stat_rd | input | 1 | Read of the line status flags |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | Mode bit: 1 buffered, 0 unbuffered |
| cfg_rx_clr | input | 1 | Flush the receive queue |
| cfg_tx_clr | input | 1 | Request a transmit queue flush |
| cfg_trig | input | 2 | Threshold code |
| char_cycles | input | CHAR_W | One character time in clock cycles |
| rd_data | output | 8 | Byte returned by a read |
| level | output | CNT_W | Queue occupancy |
| data_ready | output | 1 | Data available |
| break_flag | output | 1 | Break received |
| overrun | output | 1 | A byte was lost |
| timeout_pend | output | 1 | Character timeout pending |
| trig_reached | output | 1 | Occupancy at or above threshold |
| tx_flush | output | 1 | Transmit queue flush pulse |

## Verification
Several properties are checked on every cycle:
- the occupancy never exceeds the depth;
- a flush always leaves the queue empty with no flags;
- a read always drops the timeout flag;
- a break always sets break and data-ready;
- an arrival at full depth keeps the depth and raises overrun;
- a timer restart always arms it with the full window.

Other behaviour only shows up in the bench's scenarios, which compare against a reference queue:
- the ordering of the bytes read back;
- the exact edge on which the timeout fires after an arrival or a partial read;
- threshold switching with all four codes;
- unbuffered overwrite.

// File: rtl/uart_rx_buffer_pkg.sv
// Shared helpers for the serial receive buffer.
// Assumes thresholds are defined for a 16-deep queue.
package uart_rx_buffer_pkg;

    // Map a two-bit threshold code to a byte count.
    function automatic logic [4:0] trig_count(input logic [1:0] code);
        logic [4:0] n;
        unique case (code)
            2'b00:   n = 5'd1;
            2'b01:   n = 5'd4;
            2'b10:   n = 5'd8;
            default: n = 5'd14;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uart_rx_store.sv
// Byte queue storage with head view and occupancy count.
// Assumes DEPTH is a power of two; push on full and pop on empty are ignored.
module uart_rx_store #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [7:0]       din,
    input  logic             pop,
    input  logic             flush,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Write accepted bytes into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

endmodule

// File: rtl/uart_rx_timer.sv
// Down-counter for the character timeout; expire is high in the cycle
// before the window's last edge. Assumes stop has priority over restart.
module uart_rx_timer #(
    parameter int PER_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             stop,
    input  logic [PER_W-1:0] period,
    output logic             expire
);
    logic             armed;
    logic [PER_W-1:0] cnt;

    assign expire = armed && (cnt == PER_W'(1));

    // Load, count down and disarm on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (stop) begin
            armed <= 1'b0;
        end else if (restart) begin
            armed <= 1'b1;
            cnt   <= period;
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == PER_W'(1)) armed <= 1'b0;
        end
    end

    // R7
    restart_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !stop) |=> (armed && cnt == $past(period)));

endmodule

// File: rtl/uart_rx_buffer.sv
// Receive buffer for a serial port: queue or holding register, status
// flags and the character timeout. Assumes strobes are single-cycle.
module uart_rx_buffer
    import uart_rx_buffer_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CHAR_W = 16,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_break,
    input  logic              rd_strobe,
    input  logic              stat_rd,
    input  logic              cfg_wr,
    input  logic              cfg_fifo_en,
    input  logic              cfg_rx_clr,
    input  logic              cfg_tx_clr,
    input  logic [1:0]        cfg_trig,
    input  logic [CHAR_W-1:0] char_cycles,
    output logic [7:0]        rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              data_ready,
    output logic              break_flag,
    output logic              overrun,
    output logic              timeout_pend,
    output logic              trig_reached,
    output logic              tx_flush
);
    localparam int PER_W = CHAR_W + 2;

    logic             fifo_en;
    logic [1:0]       trig_sel;
    logic [7:0]       hold;
    logic             mode_flip;
    logic             rx_flush;
    logic             rcv;
    logic [7:0]       rcv_byte;
    logic             full;
    logic             push;
    logic             pop;
    logic [CNT_W-1:0] count_next;
    logic [7:0]       head;
    logic             restart;
    logic             stop;
    logic             expire;

    assign mode_flip  = cfg_wr && (cfg_fifo_en != fifo_en);
    assign rx_flush   = cfg_wr && (cfg_rx_clr || mode_flip);
    assign rcv        = rx_valid || rx_break;
    assign rcv_byte   = rx_break ? 8'h00 : rx_byte;
    assign full       = (level == CNT_W'(DEPTH));
    assign push       = fifo_en && rcv && !rx_flush && !full;
    assign pop        = fifo_en && rd_strobe && !rx_flush && (level != '0);
    assign count_next = level + CNT_W'(push) - CNT_W'(pop);
    assign restart    = fifo_en && !rx_flush && (rcv || (pop && count_next != '0));
    assign stop       = rx_flush || !fifo_en;

    assign rd_data      = fifo_en ? ((level != '0) ? head : 8'h00) : hold;
    assign trig_reached = fifo_en ? (level >= CNT_W'(trig_count(trig_sel))) : data_ready;

    uart_rx_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (rcv_byte),
        .pop   (pop),
        .flush (rx_flush),
        .head  (head),
        .count (level)
    );

    uart_rx_timer #(.PER_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .stop    (stop),
        .period  ({char_cycles, 2'b00}),
        .expire  (expire)
    );

    // Configuration register and transmit flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'b00;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= cfg_wr && (cfg_tx_clr || mode_flip);
            if (cfg_wr) begin
                fifo_en  <= cfg_fifo_en;
                trig_sel <= cfg_trig;
            end
        end
    end

    // Overrun: set on a lost byte, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (rcv && !rx_flush && (fifo_en ? full : data_ready)) begin
            overrun <= 1'b1;
        end else if (stat_rd) begin
            overrun <= 1'b0;
        end
    end

    // Data-ready, break, timeout flags and the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush) begin
            data_ready   <= 1'b0;
            break_flag   <= 1'b0;
            timeout_pend <= 1'b0;
            hold         <= 8'h00;
        end else if (fifo_en) begin
            data_ready <= (count_next != '0);
            if (rx_break)                            break_flag <= 1'b1;
            else if (count_next == '0 || stat_rd)    break_flag <= 1'b0;
            if (rd_strobe)                           timeout_pend <= 1'b0;
            else if (expire && level != '0)          timeout_pend <= 1'b1;
        end else begin
            timeout_pend <= 1'b0;
            if (rcv)            hold <= rcv_byte;
            if (rcv)            data_ready <= 1'b1;
            else if (rd_strobe) data_ready <= 1'b0;
            if (rx_break)                    break_flag <= 1'b1;
            else if (rd_strobe || stat_rd)   break_flag <= 1'b0;
        end
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (level == '0 && !data_ready && !break_flag && !timeout_pend));

    // R7
    read_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !timeout_pend);

    // R6
    break_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !rx_flush) |=> (break_flag && data_ready));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rcv && !rx_flush && !rd_strobe && full) |=>
        (level == CNT_W'(DEPTH) && overrun));

endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 0, rx_break = 0, rd_strobe = 0, stat_rd = 0;
    logic [7:0]  rx_byte = 0;
    logic        cfg_wr = 0, cfg_fifo_en = 0, cfg_rx_clr = 0, cfg_tx_clr = 0;
    logic [1:0]  cfg_trig = 0;
    logic [15:0] char_cycles = 16'd3;
    logic [7:0]  rd_data;
    logic [4:0]  level;
    logic        data_ready, break_flag, overrun, timeout_pend, trig_reached, tx_flush;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    byte unsigned mq[$];
    bit m_en = 0, m_dr = 0, m_brk = 0, m_ovr = 0, m_pend = 0, m_txf = 0;
    logic [1:0] m_sel = 0;
    logic [7:0] m_hold = 0;

    always #4 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .rd_strobe(rd_strobe), .stat_rd(stat_rd),
        .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en), .cfg_rx_clr(cfg_rx_clr),
        .cfg_tx_clr(cfg_tx_clr), .cfg_trig(cfg_trig), .char_cycles(char_cycles),
        .rd_data(rd_data), .level(level), .data_ready(data_ready),
        .break_flag(break_flag), .overrun(overrun), .timeout_pend(timeout_pend),
        .trig_reached(trig_reached), .tx_flush(tx_flush)
    );

    function automatic int thresh(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp(input string tag);
        int trig_e;
        trig_e = m_en ? int'(mq.size() >= thresh(m_sel)) : int'(m_dr);
        check({tag, " level"}, level, mq.size());
        check({tag, " data_ready"}, data_ready, m_dr);
        check({tag, " break_flag"}, break_flag, m_brk);
        check({tag, " overrun"}, overrun, m_ovr);
        check({tag, " timeout_pend"}, timeout_pend, m_pend);
        check({tag, " trig_reached"}, trig_reached, trig_e);
        check({tag, " tx_flush"}, tx_flush, m_txf);
    endtask

    // One clock: drive at negedge, update model, end at next negedge.
    task automatic step(input string tag, input bit rv, input byte unsigned b,
                        input bit br, input bit rd, input bit sr,
                        input bit cw, input bit ce, input bit cr, input bit ct,
                        input logic [1:0] cg);
        bit flip, fl, rcv;
        int pre;
        byte unsigned v, exp_rd;
        rx_valid = rv; rx_byte = b; rx_break = br; rd_strobe = rd; stat_rd = sr;
        cfg_wr = cw; cfg_fifo_en = ce; cfg_rx_clr = cr; cfg_tx_clr = ct; cfg_trig = cg;
        #1;
        exp_rd = m_en ? ((mq.size() != 0) ? mq[0] : 8'h00) : m_hold;
        if (rd) check({tag, " rd_data"}, rd_data, exp_rd);
        flip = cw && (ce != m_en);
        fl   = cw && (cr || flip);
        rcv  = rv || br;
        v    = br ? 8'h00 : b;
        if (rcv && !fl && (m_en ? (mq.size() == DEPTH) : m_dr)) m_ovr = 1;
        else if (sr) m_ovr = 0;
        if (fl) begin
            mq.delete(); m_dr = 0; m_brk = 0; m_pend = 0; m_hold = 0;
        end else if (m_en) begin
            pre = mq.size();
            if (rd && pre > 0) void'(mq.pop_front());
            if (rcv && pre < DEPTH) mq.push_back(v);
            m_dr = (mq.size() != 0);
            if (br) m_brk = 1;
            else if (mq.size() == 0 || sr) m_brk = 0;
            if (rd) m_pend = 0;
        end else begin
            if (rcv) m_hold = v;
            if (rcv) m_dr = 1; else if (rd) m_dr = 0;
            if (br) m_brk = 1; else if (rd || sr) m_brk = 0;
            m_pend = 0;
        end
        if (cw) begin m_en = ce; m_sel = cg; end
        m_txf = cw && (ct || flip);
        @(posedge clk);
        @(negedge clk);
        rx_valid = 0; rx_break = 0; rd_strobe = 0; stat_rd = 0; cfg_wr = 0;
        cfg_rx_clr = 0; cfg_tx_clr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic push(input string tag, input byte unsigned b);
        step(tag, 1, b, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rdb(input string tag);
        step(tag, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic cfg(input string tag, input bit ce, input bit cr, input bit ct,
                       input logic [1:0] cg);
        step(tag, 0, 0, 0, 0, 0, 1, ce, cr, ct, cg);
    endtask

    task automatic finish_sim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_sim();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1");
        check("R1 rd_data", rd_data, 0);

        // R10 unbuffered holding register and overrun
        push("R10", 8'hA5);
        cmp("R10 first");
        push("R10", 8'h3C);
        cmp("R10 overwrite");
        rdb("R10 read");
        cmp("R10 after read");
        step("R11", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        cmp("R11 overrun cleared");

        // R8 R9 mode change flushes both queues
        push("R8 prime", 8'h11);
        cfg("R9 enable", 1, 0, 0, 2'd1);
        cmp("R9 pulse");
        idle(1);
        cmp("R9 pulse ends");

        // R2 R3 ordering and thresholds
        for (int i = 0; i < 4; i++) begin
            push("R2", byte'(8'h20 + i));
            cmp("R3 code01");
        end
        cfg("R3 code10", 1, 0, 0, 2'd2);
        cmp("R3 code10");
        cfg("R3 code11", 1, 0, 0, 2'd3);
        for (int i = 4; i < DEPTH; i++) push("R2 fill", byte'(8'h20 + i));
        cmp("R3 code11 full");
        // R4 overrun at full depth, with and without same-cycle read
        push("R4 drop", 8'hEE);
        cmp("R4 drop");
        step("R4 drop+rd", 1, 8'hEF, 0, 1, 0, 0, 0, 0, 0, 0);
        cmp("R4 drop+rd");
        step("R11 clr", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH - 1; i++) rdb("R2 drain");
        cmp("R2 drained");
        // R5 empty read
        rdb("R5 empty read");
        cmp("R5 empty");

        // R6 break byte, then R11 clears break
        step("R6 break", 1, 8'h77, 1, 0, 0, 0, 0, 0, 0, 0);
        cmp("R6 break");
        push("R6 next", 8'h55);
        step("R11 brk", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        cmp("R11 break cleared");
        step("R6 break2", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        rdb("R6 null");
        rdb("R6 read 55");
        rdb("R5 drain");
        cmp("R5 break cleared at zero");

        // R7 timeout after arrival: 4*3 = 12 edges
        push("R7 arrive", 8'h81);
        idle(11);
        cmp("R7 before window");
        idle(1);
        m_pend = 1;
        cmp("R7 window end");
        // R7 partial read restarts timer and clears pending
        push("R7 second", 8'h82);
        idle(5);
        rdb("R7 read");
        cmp("R7 pend cleared");
        idle(11);
        cmp("R7 restart before");
        idle(1);
        m_pend = 1;
        cmp("R7 restart end");

        // R8 explicit receive flush keeps overrun
        for (int i = 0; i < DEPTH + 1; i++) push("R8 fill", byte'(i));
        cfg("R8 flush", 1, 1, 1, 2'd0);
        cmp("R8 flushed");
        idle(14);
        cmp("R8 timer stopped");

        // Random mixed traffic, long timeout
        char_cycles = 16'd5000;
        step("rand clr", 0, 0, 0, 0, 1, 1, 1, 1, 0, 0);
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 20;
            if (r < 7)       push("R2 rand", byte'($urandom));
            else if (r < 13) rdb("R2 rand");
            else if (r == 13) step("R6 rand", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
            else if (r == 14) step("R11 rand", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
            else if (r == 15) cfg("R3 rand", 1, 0, 0, 2'($urandom));
            else if (r == 16) step("R4 rand", 1, byte'($urandom), 0, 1, 0, 0, 0, 0, 0, 0);
            else             idle(1);
            cmp("rand");
        end

        // R10 random traffic in unbuffered mode
        cfg("R10 disable", 0, 0, 0, 2'd0);
        for (int n = 0; n < 200; n++) begin
            int r;
            r = $urandom % 6;
            if (r < 2)       push("R10 rand", byte'($urandom));
            else if (r < 4)  rdb("R10 rand");
            else if (r == 4) step("R10 brk", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
            else             step("R11 rand", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
            cmp("R10 rand");
        end

        done = 1;
        finish_sim();
    end
endmodule